// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the software-facing control and status part of a simple UART. A processor reaches it over a plain word-addressed register bus. Through that bus it sets the transmit and receive enables, programs a transmit fill threshold, pushes transmit bytes, pops received bytes and handles interrupts. The serializer and deserializer sit outside the block. The receiver signals each arriving byte with a one-cycle strobe. The transmitter signals each byte it takes from the transmit queue with a one-cycle pop strobe.

Byte storage is reduced to two fill counters and one holding register for the most recently received byte. Four level-sensitive interrupt lines are driven from a sticky pending register, masked per bit by an enable register: transmit threshold, receive data, transmit drained and receive overrun. Hardware events set pending bits. Software clears them by writing ones to the pending register. A separate write-only test register lets software force any pending bit.

Top module: `uart_regctl`

## Requirements
- R1: Each interrupt line is high exactly when its pending bit and its enable bit are both 1. Bit order in the pending, enable and test registers is: bit 0 transmit threshold (`irq_tx_wm`), bit 1 receive data (`irq_rx_wm`), bit 2 transmit drained (`irq_tx_empty`), bit 3 receive overrun (`irq_rx_ovf`).
- R2: Register offsets: pending 0x00, enable 0x04, test 0x08, control 0x0C, status 0x10, receive data 0x14, transmit data 0x18, queue control 0x1C, queue levels 0x20. Writing the pending register clears each bit written as 1. Writing the test register sets each bit written as 1. A hardware set in the same cycle as a software clear leaves the bit set.
- R3: After reset, status reads 0x3C, every other register and both fill levels read 0, and all interrupt lines are low. Status bits are: 0 tx-full, 1 rx-full, 2 tx-empty, 3 tx-idle, 4 rx-idle, 5 rx-empty.
- R4: A write to the transmit-data offset raises the transmit level by one. The write is dropped when the level already equals the capacity (32). tx-full reads 1 exactly at capacity, and tx-empty and tx-idle read 0 while the level is nonzero.
- R5: The transmit threshold occupies bits [5:0] of queue control. A push that leaves the level at or above the threshold sets pending bit 0. A pop that leaves the level below the threshold clears pending bit 0.
- R6: Control bit 0 enables transmit pops and bit 1 enables reception. A pop strobe while transmit is disabled, or while the level is 0, has no effect. A pop that brings the level to 0 sets pending bit 2, and tx-empty and tx-idle then read 1.
- R7: A received byte is accepted only while reception is enabled and rx-full is 0. Acceptance stores the byte in the holding register, raises the receive level, clears rx-idle and rx-empty, and sets pending bit 1. A byte that arrives while reception is disabled changes nothing.
- R8: rx-full reads 1 when the receive level reaches its capacity (4). A byte that arrives while rx-full is 1 is discarded, leaves the holding register unchanged, and sets pending bit 3.
- R9: A read of the receive-data offset returns the holding register. When reception is enabled and the receive level is nonzero, the read also lowers the level by one. rx-idle and rx-empty read 1 once the level is 0.
- R10: The queue-levels register reports the transmit level in bits [5:0] and the receive level in bits [18:16]. Writing queue control with bit 8 set zeroes the receive level, and with bit 9 set zeroes the transmit level. Both bits read back as 0.
- R11: Reads of the test and transmit-data offsets, and of any unmapped offset, return 0. Writes to the status, receive-data and queue-levels offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| rx_valid | input | 1 | One-cycle strobe per received byte |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | One-cycle strobe per byte taken by the serializer |
| irq_tx_wm | output | 1 | Transmit threshold interrupt |
| irq_rx_wm | output | 1 | Receive data interrupt |
| irq_tx_empty | output | 1 | Transmit drained interrupt |
| irq_rx_ovf | output | 1 | Receive overrun interrupt |

## Verification
The transmit counter is driven with pushes below, at and above the threshold, then with pops while transmit is disabled, while enabled, and at level zero. This separates a threshold compare that is off by one and a pop gate that is missing from one that works. The receive side is filled to capacity and then past it, which tells acceptance apart from overrun, and shows whether a discarded byte corrupts the holding register. Pending bits are driven by test writes, clears, and a hardware set that coincides with a clear, which shows the set-over-clear priority and the per-line masking.

// File: rtl/uart_regctl_pkg.sv
`timescale 1ns/1ps
package uart_regctl_pkg;
  localparam int NUM_IRQ  = 4;
  localparam int NUM_REGS = 9;

  // word indices of the register map
  localparam int IDX_PEND  = 0;
  localparam int IDX_IEN   = 1;
  localparam int IDX_ITEST = 2;
  localparam int IDX_CTRL  = 3;
  localparam int IDX_STAT  = 4;
  localparam int IDX_RDAT  = 5;
  localparam int IDX_WDAT  = 6;
  localparam int IDX_QCTL  = 7;
  localparam int IDX_QLVL  = 8;

  // interrupt bit positions
  localparam int IRQ_TXWM  = 0;
  localparam int IRQ_RXWM  = 1;
  localparam int IRQ_TXEMP = 2;
  localparam int IRQ_RXOVF = 3;

  // status bit positions
  localparam int ST_TXFULL  = 0;
  localparam int ST_RXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_TXIDLE  = 3;
  localparam int ST_RXIDLE  = 4;
  localparam int ST_RXEMPTY = 5;
  localparam int STAT_W     = 6;

  // control and queue-control bits
  localparam int CTRL_TXEN  = 0;
  localparam int CTRL_RXEN  = 1;
  localparam int QCTL_RXRST = 8;
  localparam int QCTL_TXRST = 9;
  localparam int QLVL_RXSH  = 16;

  typedef logic [NUM_IRQ-1:0] irq_vec_t;
endpackage

// File: rtl/uart_regctl_rstsync.sv
`timescale 1ns/1ps
module uart_regctl_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_regctl_txlvl.sv
`timescale 1ns/1ps
module uart_regctl_txlvl #(
  parameter int CAP  = 32,
  parameter int LVLW = $clog2(CAP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_req,
  input  logic            pop_req,
  input  logic            flush,
  input  logic [LVLW-1:0] thr,
  output logic [LVLW-1:0] level,
  output logic            wm_set,
  output logic            wm_clr,
  output logic            empty_set
);
  localparam logic [LVLW-1:0] CAP_L = LVLW'(CAP);

  logic            push_ok, pop_ok, lvl_en;
  logic [LVLW-1:0] lvl_nxt;

  assign push_ok = push_req && (level != CAP_L);
  assign pop_ok  = pop_req  && (level != '0);
  assign lvl_en  = flush || push_ok || pop_ok;

  always_comb begin
    lvl_nxt = level;
    if (flush)                 lvl_nxt = '0;
    else if (push_ok && !pop_ok) lvl_nxt = level + 1'b1;
    else if (pop_ok && !push_ok) lvl_nxt = level - 1'b1;
  end

  always_comb begin
    wm_set    = 1'b0;
    wm_clr    = 1'b0;
    empty_set = 1'b0;
    if (!flush) begin
      wm_set    = push_ok && (lvl_nxt >= thr);
      wm_clr    = pop_ok && !wm_set && (lvl_nxt < thr);
      empty_set = pop_ok && (lvl_nxt == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (lvl_en) level <= lvl_nxt;
  end
endmodule

// File: rtl/uart_regctl_rxlvl.sv
`timescale 1ns/1ps
module uart_regctl_rxlvl #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic            byte_vld,
  input  logic [DW-1:0]   byte_in,
  input  logic            rd_pop_req,
  input  logic            flush,
  output logic [LVLW-1:0] level,
  output logic [DW-1:0]   hold_q,
  output logic            full,
  output logic            wm_set,
  output logic            ovf_set
);
  localparam logic [LVLW-1:0] DEPTH_L = LVLW'(DEPTH);

  logic            accept, pop_ok, lvl_en;
  logic [LVLW-1:0] lvl_nxt;

  assign full    = (level == DEPTH_L);
  assign accept  = byte_vld && rx_en && !full;
  assign ovf_set = byte_vld && full;
  assign wm_set  = accept;
  assign pop_ok  = rd_pop_req && rx_en && (level != '0);
  assign lvl_en  = flush || accept || pop_ok;

  always_comb begin
    lvl_nxt = level;
    if (flush)                  lvl_nxt = '0;
    else if (accept && !pop_ok) lvl_nxt = level + 1'b1;
    else if (pop_ok && !accept) lvl_nxt = level - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (lvl_en) level <= lvl_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (accept) hold_q <= byte_in;
  end
endmodule

// File: rtl/uart_regctl_irq.sv
`timescale 1ns/1ps
module uart_regctl_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] hw_clr,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] enable,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_nxt, bit_en;
    assign bit_en  = hw_set[i] | hw_clr[i] | sw_clr[i] | sw_set[i];
    assign bit_nxt = hw_set[i] | sw_set[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[i] <= 1'b0;
      else if (bit_en) pend_q[i] <= bit_nxt;
    end

    assign irq[i] = pend_q[i] & enable[i];
  end
endmodule

// File: rtl/uart_regctl.sv
`timescale 1ns/1ps
module uart_regctl
  import uart_regctl_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_pop,
  output logic              irq_tx_wm,
  output logic              irq_rx_wm,
  output logic              irq_tx_empty,
  output logic              irq_rx_ovf
);
  localparam int TX_LVLW = $clog2(TX_DEPTH + 1);
  localparam int RX_LVLW = $clog2(RX_DEPTH + 1);
  localparam logic [TX_LVLW-1:0] TX_CAP_L = TX_LVLW'(TX_DEPTH);

  logic                rst_sync_n;
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] wr_hit;
  logic [NUM_REGS-1:0] rd_hit;

  logic [1:0]          ctrl_q;
  irq_vec_t            ien_q;
  logic [TX_LVLW-1:0]  thr_q;
  irq_vec_t            pend_q, irq_vec, hw_set, hw_clr, sw_clr, sw_set;

  logic [TX_LVLW-1:0]  tx_level;
  logic [RX_LVLW-1:0]  rx_level;
  logic [7:0]          rx_hold;
  logic                rx_full;
  logic                tx_wm_set, tx_wm_clr, tx_empty_set, rx_wm_set, rx_ovf_set;
  logic                tx_flush, rx_flush;
  logic [STAT_W-1:0]   status;
  logic                unused_bits;

  uart_regctl_rstsync #(.STAGES(2)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // address decode
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign hit[i]    = (int'(reg_addr[ADDR_W-1:2]) == i);
    assign wr_hit[i] = reg_we && hit[i];
    assign rd_hit[i] = reg_re && hit[i];
  end

  assign tx_flush = wr_hit[IDX_QCTL] && reg_wdata[QCTL_TXRST];
  assign rx_flush = wr_hit[IDX_QCTL] && reg_wdata[QCTL_RXRST];

  // software-owned configuration registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)           ctrl_q <= '0;
    else if (wr_hit[IDX_CTRL]) ctrl_q <= reg_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)          ien_q <= '0;
    else if (wr_hit[IDX_IEN]) ien_q <= reg_wdata[NUM_IRQ-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)           thr_q <= '0;
    else if (wr_hit[IDX_QCTL]) thr_q <= reg_wdata[TX_LVLW-1:0];
  end

  uart_regctl_txlvl #(.CAP(TX_DEPTH), .LVLW(TX_LVLW)) u_txlvl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_req  (wr_hit[IDX_WDAT]),
    .pop_req   (tx_pop && ctrl_q[CTRL_TXEN]),
    .flush     (tx_flush),
    .thr       (thr_q),
    .level     (tx_level),
    .wm_set    (tx_wm_set),
    .wm_clr    (tx_wm_clr),
    .empty_set (tx_empty_set)
  );

  uart_regctl_rxlvl #(.DEPTH(RX_DEPTH), .DW(8), .LVLW(RX_LVLW)) u_rxlvl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rx_en      (ctrl_q[CTRL_RXEN]),
    .byte_vld   (rx_valid),
    .byte_in    (rx_byte),
    .rd_pop_req (rd_hit[IDX_RDAT]),
    .flush      (rx_flush),
    .level      (rx_level),
    .hold_q     (rx_hold),
    .full       (rx_full),
    .wm_set     (rx_wm_set),
    .ovf_set    (rx_ovf_set)
  );

  always_comb begin
    hw_set            = '0;
    hw_set[IRQ_TXWM]  = tx_wm_set;
    hw_set[IRQ_RXWM]  = rx_wm_set;
    hw_set[IRQ_TXEMP] = tx_empty_set;
    hw_set[IRQ_RXOVF] = rx_ovf_set;
    hw_clr            = '0;
    hw_clr[IRQ_TXWM]  = tx_wm_clr;
  end

  assign sw_clr = wr_hit[IDX_PEND]  ? reg_wdata[NUM_IRQ-1:0] : '0;
  assign sw_set = wr_hit[IDX_ITEST] ? reg_wdata[NUM_IRQ-1:0] : '0;

  uart_regctl_irq #(.N(NUM_IRQ)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hw_set (hw_set),
    .hw_clr (hw_clr),
    .sw_clr (sw_clr),
    .sw_set (sw_set),
    .enable (ien_q),
    .pend_q (pend_q),
    .irq    (irq_vec)
  );

  assign irq_tx_wm    = irq_vec[IRQ_TXWM];
  assign irq_rx_wm    = irq_vec[IRQ_RXWM];
  assign irq_tx_empty = irq_vec[IRQ_TXEMP];
  assign irq_rx_ovf   = irq_vec[IRQ_RXOVF];

  // status derived from the fill levels
  always_comb begin
    status             = '0;
    status[ST_TXFULL]  = (tx_level == TX_CAP_L);
    status[ST_RXFULL]  = rx_full;
    status[ST_TXEMPTY] = (tx_level == '0);
    status[ST_TXIDLE]  = (tx_level == '0);
    status[ST_RXIDLE]  = (rx_level == '0);
    status[ST_RXEMPTY] = (rx_level == '0);
  end

  // read mux; write-only and unmapped offsets return zero
  always_comb begin
    reg_rdata = '0;
    if (reg_re) begin
      unique case (1'b1)
        hit[IDX_PEND]: reg_rdata = 32'(pend_q);
        hit[IDX_IEN]:  reg_rdata = 32'(ien_q);
        hit[IDX_CTRL]: reg_rdata = 32'(ctrl_q);
        hit[IDX_STAT]: reg_rdata = 32'(status);
        hit[IDX_RDAT]: reg_rdata = 32'(rx_hold);
        hit[IDX_QCTL]: reg_rdata = 32'(thr_q);
        hit[IDX_QLVL]: reg_rdata = 32'(tx_level) | (32'(rx_level) << QLVL_RXSH);
        default:       reg_rdata = '0;
      endcase
    end
  end

  assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:10]};
endmodule

// File: rtl/uart_regctl_chk.sv
`timescale 1ns/1ps
module uart_regctl_chk
  import uart_regctl_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CAP     = 32,
  parameter int TX_LVLW = 6,
  parameter int RX_LVLW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic               rx_valid,
  input logic               tx_pop,
  input logic               rx_en,
  input logic               rx_full,
  input logic [3:0]         irq_o,
  input logic [3:0]         pend,
  input logic [3:0]         ien,
  input logic [TX_LVLW-1:0] tx_level,
  input logic [RX_LVLW-1:0] rx_level
);
  logic w_pend, w_test, w_wdat, w_qctl;
  assign w_pend = reg_we && (int'(reg_addr[ADDR_W-1:2]) == IDX_PEND);
  assign w_test = reg_we && (int'(reg_addr[ADDR_W-1:2]) == IDX_ITEST);
  assign w_wdat = reg_we && (int'(reg_addr[ADDR_W-1:2]) == IDX_WDAT);
  assign w_qctl = reg_we && (int'(reg_addr[ADDR_W-1:2]) == IDX_QCTL);

  assert_irq_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> (|(pend & ien)));

  assert_clear_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_pend && reg_wdata[3:0] == 4'hF && !rx_valid && !tx_pop) |=> (pend == 4'h0));

  assert_test_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    w_test |=> ((pend & $past(reg_wdata[3:0])) == $past(reg_wdata[3:0])));

  assert_tx_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_level) <= CAP);

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_wdat && int'(tx_level) == CAP && !tx_pop) |=> (int'(tx_level) == CAP));

  assert_rx_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_en && !w_qctl) |=> $stable(rx_level));

  assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full) |=> pend[IRQ_RXOVF]);
endmodule

bind uart_regctl uart_regctl_chk #(
  .ADDR_W(ADDR_W), .CAP(TX_DEPTH), .TX_LVLW(TX_LVLW), .RX_LVLW(RX_LVLW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .rx_valid  (rx_valid),
  .tx_pop    (tx_pop),
  .rx_en     (ctrl_q[1]),
  .rx_full   (rx_full),
  .irq_o     (irq_vec),
  .pend      (pend_q),
  .ien       (ien_q),
  .tx_level  (tx_level),
  .rx_level  (rx_level)
);

// File: tb/test_uart_regctl.sv
`timescale 1ns/1ps
module test_uart_regctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_pop = 1'b0;
  logic        irq_tx_wm, irq_rx_wm, irq_tx_empty, irq_rx_ovf;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [5:0] A_PEND = 6'h00, A_IEN = 6'h04, A_TEST = 6'h08, A_CTRL = 6'h0C,
                         A_STAT = 6'h10, A_RDAT = 6'h14, A_WDAT = 6'h18, A_QCTL = 6'h1C,
                         A_QLVL = 6'h20;

  always #2 clk = ~clk;

  uart_regctl i_uart_regctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_pop(tx_pop), .irq_tx_wm(irq_tx_wm), .irq_rx_wm(irq_rx_wm),
    .irq_tx_empty(irq_tx_empty), .irq_rx_ovf(irq_rx_ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_re = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic pop1;
    @(negedge clk);
    tx_pop = 1'b1;
    @(posedge clk); #1;
    tx_pop = 1'b0;
  endtask

  function automatic logic [31:0] irqs();
    return {28'h0, irq_rx_ovf, irq_tx_empty, irq_rx_wm, irq_tx_wm};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk("R3 irq lines", irqs(), 32'h0);
    rd_chk("R3 status", A_STAT, 32'h3C);
    rd_chk("R3 pending", A_PEND, 32'h0);
    rd_chk("R3 enable", A_IEN, 32'h0);
    rd_chk("R3 control", A_CTRL, 32'h0);
    rd_chk("R3 levels", A_QLVL, 32'h0);
    rd_chk("R3 rdata", A_RDAT, 32'h0);
  endtask

  task automatic t_irq_regs;
    wr(A_IEN, 32'hF);
    wr(A_TEST, 32'h5);
    @(negedge clk);
    chk("R1 lines after test", irqs(), 32'h5);
    rd_chk("R2 test sets", A_PEND, 32'h5);
    wr(A_PEND, 32'h1);
    rd_chk("R2 w1c", A_PEND, 32'h4);
    @(negedge clk);
    chk("R1 line follows pend", irqs(), 32'h4);
    wr(A_IEN, 32'h0);
    @(negedge clk);
    chk("R1 masked", irqs(), 32'h0);
    rd_chk("R1 pend kept when masked", A_PEND, 32'h4);
    wr(A_PEND, 32'hF);
    rd_chk("R2 clear all", A_PEND, 32'h0);
  endtask

  task automatic t_tx;
    wr(A_QCTL, 32'h4);
    for (int i = 0; i < 3; i++) wr(A_WDAT, 32'h40 + i);
    rd_chk("R5 below threshold", A_PEND, 32'h0);
    rd_chk("R4 level 3", A_QLVL, 32'h3);
    rd_chk("R4 not empty", A_STAT, 32'h30);
    wr(A_WDAT, 32'h43);
    rd_chk("R5 at threshold", A_PEND, 32'h1);
    pop1();
    rd_chk("R6 pop while tx off", A_QLVL, 32'h4);
    wr(A_CTRL, 32'h1);
    pop1();
    rd_chk("R6 pop level", A_QLVL, 32'h3);
    rd_chk("R5 wm cleared", A_PEND, 32'h0);
    for (int i = 0; i < 3; i++) pop1();
    rd_chk("R6 drained level", A_QLVL, 32'h0);
    rd_chk("R6 empty pending", A_PEND, 32'h4);
    rd_chk("R6 empty status", A_STAT, 32'h3C);
    pop1();
    rd_chk("R6 pop at zero", A_QLVL, 32'h0);
    wr(A_PEND, 32'hF);
  endtask

  task automatic t_full;
    for (int i = 0; i < 32; i++) wr(A_WDAT, i);
    rd_chk("R4 level at cap", A_QLVL, 32'h20);
    rd_chk("R4 full status", A_STAT, 32'h31);
    wr(A_WDAT, 32'hEE);
    rd_chk("R4 push dropped", A_QLVL, 32'h20);
    wr(A_QCTL, 32'h204);
    rd_chk("R10 tx flush", A_QLVL, 32'h0);
    rd_chk("R10 reset bits read 0", A_QCTL, 32'h4);
    rd_chk("R10 status after flush", A_STAT, 32'h3C);
    wr(A_PEND, 32'hF);
  endtask

  task automatic t_rx;
    wr(A_CTRL, 32'h0);
    send(8'h5A);
    rd_chk("R7 rx disabled level", A_QLVL, 32'h0);
    rd_chk("R7 rx disabled pend", A_PEND, 32'h0);
    wr(A_CTRL, 32'h2);
    send(8'hA5);
    rd_chk("R7 accept status", A_STAT, 32'h0C);
    rd_chk("R10 rx field", A_QLVL, 32'h10000);
    rd_chk("R7 rx wm pend", A_PEND, 32'h2);
    send(8'h11); send(8'h22); send(8'h33);
    rd_chk("R8 rx full level", A_QLVL, 32'h40000);
    rd_chk("R8 rx full status", A_STAT, 32'h0E);
    send(8'h44);
    rd_chk("R8 overflow pend", A_PEND, 32'hA);
    wr(A_IEN, 32'hF);
    @(negedge clk);
    chk("R1 rx lines", irqs(), 32'hA);
    wr(A_IEN, 32'h2);
    @(negedge clk);
    chk("R1 partial mask", irqs(), 32'h2);
    rd_chk("R8 discarded byte", A_RDAT, 32'h33);
    rd_chk("R9 pop level", A_QLVL, 32'h30000);
    rd_chk("R9 not full", A_STAT, 32'h0C);
    for (int i = 0; i < 3; i++) rd_chk("R9 holding value", A_RDAT, 32'h33);
    rd_chk("R9 drained level", A_QLVL, 32'h0);
    rd_chk("R9 drained status", A_STAT, 32'h3C);
    rd_chk("R9 read at zero", A_RDAT, 32'h33);
    rd_chk("R9 level stays zero", A_QLVL, 32'h0);
    send(8'h77);
    wr(A_CTRL, 32'h0);
    rd_chk("R9 rdata while rx off", A_RDAT, 32'h77);
    rd_chk("R9 no pop while rx off", A_QLVL, 32'h10000);
    wr(A_QCTL, 32'h104);
    rd_chk("R10 rx flush", A_QLVL, 32'h0);
    wr(A_PEND, 32'hF);
  endtask

  task automatic t_set_wins;
    wr(A_CTRL, 32'h2);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_PEND; reg_wdata = 32'h2;
    rx_valid = 1'b1; rx_byte = 8'h99;
    @(posedge clk); #1;
    reg_we = 1'b0; rx_valid = 1'b0;
    rd_chk("R2 hw set beats clear", A_PEND, 32'h2);
    wr(A_QCTL, 32'h104);
    wr(A_PEND, 32'hF);
  endtask

  task automatic t_misc;
    wr(A_TEST, 32'h0);
    rd_chk("R11 test reads 0", A_TEST, 32'h0);
    rd_chk("R11 wdata reads 0", A_WDAT, 32'h0);
    rd_chk("R11 unmapped reads 0", 6'h24, 32'h0);
    wr(A_STAT, 32'hFFFF);
    rd_chk("R11 status write ignored", A_STAT, 32'h3C);
    wr(A_QLVL, 32'hFFFF_FFFF);
    rd_chk("R11 levels write ignored", A_QLVL, 32'h0);
    wr(A_RDAT, 32'h12);
    rd_chk("R11 rdata write ignored", A_RDAT, 32'h99);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_irq_regs();
    t_tx();
    t_full();
    t_rx();
    t_set_wins();
    t_misc();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end
endmodule